// File: doc/BRIEF.md
# Floppy controller command/result sequencer

This block is the host-facing front end of a classic floppy disk controller. The CPU sees two byte-wide registers. Address 0 is a read-only main status byte. Address 1 is a data port, and every command byte goes in and every result byte comes out through it. The block stores the command bytes. It works out from the opcode how many bytes the command takes and how many bytes it returns. It then runs a fixed-length execution step and hands the result bytes back one per read.

The execution step has no media behind it. It builds the status bytes from four drive condition inputs (ready, write protect, fault, two-sided) for the drive that the command selects. It also keeps one present-cylinder register and a pending-interrupt flag, and reports that flag on `irq`. Positioning commands move the cylinder and raise the flag. The interrupt-status query reports the flag and clears it.

Top module: `fdc_seq_top`

## Requirements
- R1: After reset the status byte reads 0x80, `irq` is low, the cylinder is 0, and a data-port read returns 0x00.
- R2: The status byte is laid out as bit7 = request-for-master, bit6 = direction (1 means controller to host), bit5 = executing, bit4 = busy, bits3:0 = seeking drive 3..0. It reads 0x80 when idle, 0x90 while collecting command bytes and 0xD0 while results are pending.
- R3: The opcode is bits 4:0 of the first command byte, and bits 7:5 are flags that do not affect decoding. The command lengths in bytes are: 0x02/0x05/0x06/0x09/0x0C/0x11/0x19/0x1D take 9; 0x0D takes 6; 0x03 and 0x0F take 3; 0x04/0x07/0x0A take 2; every other opcode takes 1.
- R4: Execution starts with the last command byte and lasts exactly EXEC_CYCLES clocks, with status bits 7:4 = 0011. During a seek (0x0F) or recalibrate (0x07), bits 3:0 show a one-hot flag for the unit in bits 1:0 of the second byte.
- R5: Seek sets the cylinder to the third command byte, and recalibrate sets it to 0. Both return no result bytes, set `irq`, and store an interrupt status byte of 0x20 | head<<2 | unit, where head is bit 2 of the second byte.
- R6: Sense interrupt status (0x08) with `irq` set returns the stored status byte, then the cylinder, and clears `irq`. With `irq` clear it returns the single byte 0x80.
- R7: Sense drive status (0x04) returns one byte: bit7 fault, bit6 write protect, bit5 ready, bit4 cylinder==0, bit3 two-sided, bit2 head, bits1:0 unit.
- R8: The 9-byte transfer commands return seven bytes: ST0, ST1, ST2, then command bytes 2..5. ST0 = head<<2 | unit. If the drive is not ready, ST0 also has 0x48 set. If the drive is ready and write protected and the opcode is 0x05, 0x09 or 0x0D, ST0 has 0x40 set and ST1 = 0x02. ST1 and ST2 are otherwise 0.
- R9: Read ID (0x0A) and format (0x0D) return ST0, ST1, ST2 by the same rules as R8, then the cylinder, the head bit, 0x01 and 0x02.
- R10: An opcode outside the defined set is taken as a one-byte command and returns the single byte 0x80.
- R11: Specify (0x03) returns no result bytes. Any command with no results goes from execution straight to idle, and every other command goes to idle after its last result byte is read.
- R12: A data-port strobe that does not match the current direction has no effect. This covers reads while collecting, writes while results are pending, and both strobes at once, where only the matching one acts.
- R13: Reading the status byte never changes the phase, the byte counts or any stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for a one-cycle access |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 1 | 0 = status byte, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Pending-interrupt flag |
| drv_ready | input | 1 | Selected drive is ready |
| drv_wprot | input | 1 | Selected drive is write protected |
| drv_fault | input | 1 | Selected drive reports a fault |
| drv_two_side | input | 1 | Selected drive is two-sided |

## Verification
Two things can meet in one cycle: a host read strobe and a host write strobe to the data port. The bench provokes this by raising both together, once while command bytes are being collected and once while results are pending. It judges the outcome by the status byte, the byte returned and the bytes that follow. The write must land in the first case, and the read must pop one result with the write dropped in the second. Random command streams with random flag bits, parameters and drive conditions then run against a bench model of the cylinder and interrupt state.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_EXEC = 2'd2,
    PH_RES  = 2'd3
  } phase_t;

  localparam logic [4:0] OP_READ_TRACK = 5'h02;
  localparam logic [4:0] OP_SPECIFY    = 5'h03;
  localparam logic [4:0] OP_SENSE_DRV  = 5'h04;
  localparam logic [4:0] OP_WRITE      = 5'h05;
  localparam logic [4:0] OP_READ       = 5'h06;
  localparam logic [4:0] OP_RECAL      = 5'h07;
  localparam logic [4:0] OP_SENSE_INT  = 5'h08;
  localparam logic [4:0] OP_WRITE_DEL  = 5'h09;
  localparam logic [4:0] OP_READ_ID    = 5'h0A;
  localparam logic [4:0] OP_READ_DEL   = 5'h0C;
  localparam logic [4:0] OP_FORMAT     = 5'h0D;
  localparam logic [4:0] OP_SEEK       = 5'h0F;
  localparam logic [4:0] OP_SCAN_EQ    = 5'h11;
  localparam logic [4:0] OP_SCAN_LE    = 5'h19;
  localparam logic [4:0] OP_SCAN_HE    = 5'h1D;

  localparam logic [7:0] BYTE_INVALID = 8'h80;

  // bytes the host writes, opcode byte included
  function automatic logic [3:0] cmd_bytes(input logic [4:0] op);
    case (op)
      OP_READ_TRACK, OP_WRITE, OP_READ, OP_WRITE_DEL, OP_READ_DEL,
      OP_SCAN_EQ, OP_SCAN_LE, OP_SCAN_HE:   return 4'd9;
      OP_FORMAT:                            return 4'd6;
      OP_SPECIFY, OP_SEEK:                  return 4'd3;
      OP_SENSE_DRV, OP_RECAL, OP_READ_ID:   return 4'd2;
      default:                              return 4'd1;
    endcase
  endfunction

  // bytes the host reads back (sense-interrupt without a pending flag is cut to 1)
  function automatic logic [3:0] res_bytes(input logic [4:0] op);
    case (op)
      OP_READ_TRACK, OP_WRITE, OP_READ, OP_WRITE_DEL, OP_READ_DEL,
      OP_SCAN_EQ, OP_SCAN_LE, OP_SCAN_HE,
      OP_READ_ID, OP_FORMAT:                return 4'd7;
      OP_SENSE_INT:                         return 4'd2;
      OP_SPECIFY, OP_RECAL, OP_SEEK:        return 4'd0;
      default:                              return 4'd1;
    endcase
  endfunction

  function automatic logic writes_media(input logic [4:0] op);
    return (op == OP_WRITE) || (op == OP_WRITE_DEL) || (op == OP_FORMAT);
  endfunction

  function automatic logic moves_head(input logic [4:0] op);
    return (op == OP_SEEK) || (op == OP_RECAL);
  endfunction

  function automatic logic [7:0] pack_st0(input logic [1:0] ic, input logic se,
                                          input logic nr, input logic hd,
                                          input logic [1:0] us);
    return {ic, se, 1'b0, nr, hd, us};
  endfunction

  function automatic logic [7:0] pack_st3(input logic ft, input logic wp, input logic ry,
                                          input logic t0, input logic ts, input logic hd,
                                          input logic [1:0] us);
    return {ft, wp, ry, t0, ts, hd, us};
  endfunction

endpackage

// File: rtl/fdc_cmd_buf.sv
module fdc_cmd_buf #(
  parameter int DEPTH = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic                           push,
  input  logic [7:0]                     din,
  output logic [7:0]                     bytes_o [DEPTH],
  output logic [$clog2(DEPTH+1)-1:0]     count_o
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [7:0]       mem   [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (start) begin
      mem[0] <= din;
      cnt_q  <= CNT_W'(1);
    end else if (push && (cnt_q < CNT_W'(DEPTH))) begin
      mem[cnt_q] <= din;
      cnt_q      <= cnt_q + CNT_W'(1);
    end
  end

  assign bytes_o = mem;
  assign count_o = cnt_q;

  a_r3_buf_bound: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (cnt_q <= CNT_W'(DEPTH)));

endmodule

// File: rtl/fdc_result_gen.sv
module fdc_result_gen
  import fdc_pkg::*;
#(
  parameter int CMD_DEPTH = 10,
  parameter int RES_DEPTH = 8,
  parameter int RL_W      = 4
) (
  input  logic [7:0]      cmd_i [CMD_DEPTH],
  input  logic [7:0]      cyl_i,
  input  logic            irq_i,
  input  logic [7:0]      int_st0_i,
  input  logic            drv_ready_i,
  input  logic            drv_wprot_i,
  input  logic            drv_fault_i,
  input  logic            drv_two_side_i,
  output logic [7:0]      res_o [RES_DEPTH],
  output logic [RL_W-1:0] res_len_o,
  output logic            cyl_we_o,
  output logic [7:0]      cyl_o,
  output logic            irq_set_o,
  output logic            irq_clr_o,
  output logic [7:0]      int_st0_o
);
  logic [4:0] op;
  logic [1:0] us;
  logic       hd;
  logic       not_rdy;
  logic       wp_fail;
  logic [7:0] st0_xfer;

  assign op       = cmd_i[0][4:0];
  assign us       = cmd_i[1][1:0];
  assign hd       = cmd_i[1][2];
  assign not_rdy  = !drv_ready_i;
  assign wp_fail  = drv_ready_i && drv_wprot_i && writes_media(op);
  assign st0_xfer = pack_st0({1'b0, not_rdy || wp_fail}, 1'b0, not_rdy, hd, us);

  always_comb begin
    for (int i = 0; i < RES_DEPTH; i++) res_o[i] = 8'h00;
    res_len_o = RL_W'(res_bytes(op));
    cyl_we_o  = 1'b0;
    cyl_o     = cyl_i;
    irq_set_o = 1'b0;
    irq_clr_o = 1'b0;
    int_st0_o = int_st0_i;
    case (op)
      OP_SPECIFY: ;
      OP_SENSE_DRV:
        res_o[0] = pack_st3(drv_fault_i, drv_wprot_i, drv_ready_i, cyl_i == 8'h00,
                            drv_two_side_i, hd, us);
      OP_RECAL, OP_SEEK: begin
        cyl_we_o  = 1'b1;
        cyl_o     = (op == OP_SEEK) ? cmd_i[2] : 8'h00;
        irq_set_o = 1'b1;
        int_st0_o = pack_st0(2'b00, 1'b1, 1'b0, hd, us);
      end
      OP_SENSE_INT: begin
        if (irq_i) begin
          res_o[0]  = int_st0_i;
          res_o[1]  = cyl_i;
          irq_clr_o = 1'b1;
        end else begin
          res_o[0]  = BYTE_INVALID;
          res_len_o = RL_W'(1);
        end
      end
      OP_READ_TRACK, OP_WRITE, OP_READ, OP_WRITE_DEL, OP_READ_DEL,
      OP_SCAN_EQ, OP_SCAN_LE, OP_SCAN_HE, OP_READ_ID, OP_FORMAT: begin
        res_o[0] = st0_xfer;
        res_o[1] = wp_fail ? 8'h02 : 8'h00;
        res_o[2] = 8'h00;
        if (cmd_bytes(op) == 4'd9) begin
          for (int k = 0; k < 4; k++) res_o[3+k] = cmd_i[2+k];
        end else begin
          res_o[3] = cyl_i;
          res_o[4] = {7'b0, hd};
          res_o[5] = 8'h01;
          res_o[6] = 8'h02;
        end
      end
      default: res_o[0] = BYTE_INVALID;
    endcase
  end

endmodule

// File: rtl/fdc_seq_top.sv
module fdc_seq_top
  import fdc_pkg::*;
#(
  parameter int CMD_DEPTH   = 10,
  parameter int RES_DEPTH   = 8,
  parameter int EXEC_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  input  logic       drv_ready,
  input  logic       drv_wprot,
  input  logic       drv_fault,
  input  logic       drv_two_side
);
  localparam int CI_W = $clog2(CMD_DEPTH+1);
  localparam int RL_W = $clog2(RES_DEPTH+1);
  localparam int RI_W = $clog2(RES_DEPTH);
  localparam int EC_W = $clog2(EXEC_CYCLES+1);

  phase_t          phase_q;
  logic [EC_W-1:0] exec_cnt;
  logic [7:0]      cyl_q;
  logic            irq_q;
  logic [7:0]      int_st0_q;
  logic [7:0]      res_q [RES_DEPTH];
  logic [RL_W-1:0] res_len_q;
  logic [RI_W-1:0] ridx;

  logic [7:0]      cmd_q [CMD_DEPTH];
  logic [CI_W-1:0] cmd_cnt;

  // named events
  logic host_wr, host_rd, data_wr, data_rd;
  logic cmd_last, exec_done, last_pop;
  logic [4:0] op_q, cur_op;
  logic [3:0] need;

  assign host_wr   = cs && wr && addr;
  assign host_rd   = cs && rd && addr;
  assign data_wr   = host_wr && ((phase_q == PH_IDLE) || (phase_q == PH_CMD));
  assign data_rd   = host_rd && (phase_q == PH_RES);
  assign op_q      = cmd_q[0][4:0];
  assign cur_op    = (phase_q == PH_IDLE) ? wdata[4:0] : op_q;
  assign need      = cmd_bytes(cur_op);
  assign cmd_last  = data_wr && ((phase_q == PH_IDLE) ? (need == 4'd1)
                                                      : (int'(cmd_cnt) + 1 == int'(need)));
  assign exec_done = (phase_q == PH_EXEC) && (exec_cnt == '0);
  assign last_pop  = data_rd && (int'(ridx) + 1 == int'(res_len_q));

  fdc_cmd_buf #(.DEPTH(CMD_DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (data_wr && (phase_q == PH_IDLE)),
    .push    (data_wr && (phase_q == PH_CMD)),
    .din     (wdata),
    .bytes_o (cmd_q),
    .count_o (cmd_cnt)
  );

  logic [7:0]      gen_res [RES_DEPTH];
  logic [RL_W-1:0] gen_len;
  logic            gen_cyl_we, gen_irq_set, gen_irq_clr;
  logic [7:0]      gen_cyl, gen_st0;

  fdc_result_gen #(.CMD_DEPTH(CMD_DEPTH), .RES_DEPTH(RES_DEPTH), .RL_W(RL_W)) u_gen (
    .cmd_i          (cmd_q),
    .cyl_i          (cyl_q),
    .irq_i          (irq_q),
    .int_st0_i      (int_st0_q),
    .drv_ready_i    (drv_ready),
    .drv_wprot_i    (drv_wprot),
    .drv_fault_i    (drv_fault),
    .drv_two_side_i (drv_two_side),
    .res_o          (gen_res),
    .res_len_o      (gen_len),
    .cyl_we_o       (gen_cyl_we),
    .cyl_o          (gen_cyl),
    .irq_set_o      (gen_irq_set),
    .irq_clr_o      (gen_irq_clr),
    .int_st0_o      (gen_st0)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      exec_cnt  <= '0;
      cyl_q     <= 8'h00;
      irq_q     <= 1'b0;
      int_st0_q <= 8'h00;
      res_len_q <= '0;
      ridx      <= '0;
      for (int i = 0; i < RES_DEPTH; i++) res_q[i] <= 8'h00;
    end else begin
      case (phase_q)
        PH_IDLE, PH_CMD: begin
          if (data_wr) begin
            phase_q  <= cmd_last ? PH_EXEC : PH_CMD;
            exec_cnt <= EC_W'(EXEC_CYCLES - 1);
          end
        end
        PH_EXEC: begin
          if (exec_done) begin
            res_q     <= gen_res;
            res_len_q <= gen_len;
            ridx      <= '0;
            phase_q   <= (gen_len == '0) ? PH_IDLE : PH_RES;
            if (gen_cyl_we)  cyl_q <= gen_cyl;
            if (gen_irq_set) begin
              irq_q     <= 1'b1;
              int_st0_q <= gen_st0;
            end
            if (gen_irq_clr) irq_q <= 1'b0;
          end else begin
            exec_cnt <= exec_cnt - EC_W'(1);
          end
        end
        PH_RES: begin
          if (data_rd) begin
            if (last_pop) phase_q <= PH_IDLE;
            else          ridx    <= ridx + RI_W'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  logic [3:0] seek_bits;
  logic [7:0] msr;
  assign seek_bits = ((phase_q == PH_EXEC) && moves_head(op_q)) ? (4'b0001 << cmd_q[1][1:0]) : 4'b0000;
  assign msr       = {phase_q != PH_EXEC, phase_q == PH_RES, phase_q == PH_EXEC,
                      phase_q != PH_IDLE, seek_bits};
  assign rdata     = !addr ? msr : ((phase_q == PH_RES) ? res_q[ridx] : 8'h00);
  assign irq       = irq_q;

  // R4: execution length
  a_r4_exec_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_EXEC) && !exec_done) |=> (phase_q == PH_EXEC));
  a_r4_exec_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    exec_done |=> (phase_q != PH_EXEC));
  // R5: positioning outcome
  a_r5_seek_cyl: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && (op_q == OP_SEEK)) |=> (irq_q && (cyl_q == $past(cmd_q[2]))));
  a_r5_recal_cyl: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && (op_q == OP_RECAL)) |=> (irq_q && (cyl_q == 8'h00)));
  // R6: interrupt acknowledge
  a_r6_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_done && (op_q == OP_SENSE_INT) && irq_q) |=> !irq_q);
  // R11: last result returns to idle
  a_r11_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last_pop |=> (phase_q == PH_IDLE));
  // R12: stray writes while results pend
  a_r12_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_RES) && host_wr && !host_rd) |=> ((phase_q == PH_RES) && $stable(ridx)));
  // R13: status reads are side-effect free
  a_r13_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr && !addr && (phase_q != PH_EXEC)) |=> ($stable(phase_q) && $stable(cmd_cnt)));

endmodule

// File: tb/tb_fdc_seq_top.sv
module tb_fdc_seq_top;
  localparam int E_CYC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;
  logic rdy = 1'b1, wp = 1'b0, ft = 1'b0, ts = 1'b0;

  always #5 clk = ~clk;

  fdc_seq_top #(.EXEC_CYCLES(E_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .drv_ready(rdy), .drv_wprot(wp), .drv_fault(ft), .drv_two_side(ts)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] cb [0:9];
  int         cn;
  logic [7:0] er [0:7];
  int         en;
  logic [7:0] m_cyl = 8'h00, m_ist0 = 8'h00;
  logic       m_irq = 1'b0;
  logic [7:0] v;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // all bus tasks start and end on a falling edge
  task automatic wr_data(input logic [7:0] d);
    cs = 1; wr = 1; rd = 0; addr = 1; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask
  task automatic rd_reg(input logic a, output logic [7:0] d);
    cs = 1; rd = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask
  task automatic both(input logic [7:0] d, output logic [7:0] q);
    cs = 1; rd = 1; wr = 1; addr = 1; wdata = d;
    #1 q = rdata;
    @(negedge clk); cs = 0; rd = 0; wr = 0;
  endtask

  function automatic int w_len(input logic [4:0] op);
    if (op inside {5'h02, 5'h05, 5'h06, 5'h09, 5'h0C, 5'h11, 5'h19, 5'h1D}) return 9;
    if (op == 5'h0D) return 6;
    if (op inside {5'h03, 5'h0F}) return 3;
    if (op inside {5'h04, 5'h07, 5'h0A}) return 2;
    return 1;
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    if (op inside {5'h0A, 5'h0D}) return "R9";
    if (w_len(op) == 9) return "R8";
    if (op == 5'h04) return "R7";
    if (op == 5'h08) return "R6";
    if (op inside {5'h07, 5'h0F}) return "R5";
    if (op == 5'h03) return "R11";
    return "R10";
  endfunction

  // bench model of the execution outcome
  task automatic model_exec();
    logic [4:0] op = cb[0][4:0];
    logic [1:0] us = cb[1][1:0];
    logic       hd = cb[1][2];
    logic [7:0] base = {5'b0, hd, us};
    for (int i = 0; i < 8; i++) er[i] = 8'h00;
    en = 1;
    if (w_len(op) == 9 || op == 5'h0A || op == 5'h0D) begin
      en = 7;
      if (!rdy) er[0] = base | 8'h48;
      else if (wp && op inside {5'h05, 5'h09, 5'h0D}) begin
        er[0] = base | 8'h40; er[1] = 8'h02;
      end else er[0] = base;
      if (w_len(op) == 9) begin
        er[3] = cb[2]; er[4] = cb[3]; er[5] = cb[4]; er[6] = cb[5];
      end else begin
        er[3] = m_cyl; er[4] = {7'b0, hd}; er[5] = 8'h01; er[6] = 8'h02;
      end
    end else if (op == 5'h04) begin
      er[0] = base | {ft, wp, rdy, m_cyl == 8'h00, ts, 3'b000};
    end else if (op == 5'h07 || op == 5'h0F) begin
      en = 0; m_cyl = (op == 5'h0F) ? cb[2] : 8'h00;
      m_irq = 1; m_ist0 = base | 8'h20;
    end else if (op == 5'h03) begin
      en = 0;
    end else if (op == 5'h08 && m_irq) begin
      en = 2; er[0] = m_ist0; er[1] = m_cyl; m_irq = 0;
    end else begin
      er[0] = 8'h80;
    end
  endtask

  task automatic wait_exec(input string tag, input logic [3:0] seekb);
    int n = 0;
    forever begin
      rd_reg(0, v);
      if (v[7] || n > 40) break;
      if (n == 0) chk({tag, "/R4 exec status"}, v, {4'b0011, seekb});
      n++;
    end
    chk("R4 exec length", 8'(n), 8'(E_CYC));
  endtask

  task automatic run_cmd();
    string tag = tag_of(cb[0][4:0]);
    logic [3:0] sb = (cb[0][4:0] inside {5'h07, 5'h0F}) ? (4'b0001 << cb[1][1:0]) : 4'b0000;
    for (int i = 0; i < cn; i++) begin
      rd_reg(0, v);
      chk("R2 collect status", v, (i == 0) ? 8'h80 : 8'h90);
      wr_data(cb[i]);
    end
    wait_exec(tag, sb);
    model_exec();
    chk({tag, "/R11 status after exec"}, v, (en == 0) ? 8'h80 : 8'hD0);
    for (int i = 0; i < en; i++) begin
      rd_reg(1, v);
      chk(tag, v, er[i]);
    end
    rd_reg(0, v);
    chk("R11 idle after results", v, 8'h80);
    chk({tag, " irq"}, {7'b0, irq}, {7'b0, m_irq});
  endtask

  task automatic set_cmd(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    cb[0] = b0; cb[1] = b1; cb[2] = b2;
    for (int i = 3; i < 10; i++) cb[i] = 8'(8'h30 + i);
    cn = w_len(b0[4:0]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [0:20] = '{8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09,
                               8'h0A, 8'h0C, 8'h0D, 8'h0F, 8'h11, 8'h19, 8'h1D,
                               8'h00, 8'h01, 8'h0B, 8'h0E, 8'h10, 8'h1F};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_reg(0, v); chk("R1 status", v, 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_reg(1, v); chk("R1 data idle", v, 8'h00);

    // R6 no pending interrupt, R10 invalid opcode with flags
    set_cmd(8'h08, 8'h00, 8'h00); run_cmd();
    set_cmd(8'hFF, 8'h00, 8'h00); run_cmd();
    set_cmd(8'h03, 8'hAF, 8'h02); run_cmd();   // R11 no-result command

    // R5 seek, R7 drive status, R6 acknowledge
    set_cmd(8'h0F, 8'h06, 8'h25); run_cmd();
    rdy = 1; wp = 1; ft = 0; ts = 1;
    set_cmd(8'h04, 8'h06, 8'h00); run_cmd();
    set_cmd(8'h08, 8'h00, 8'h00); run_cmd();
    set_cmd(8'h07, 8'h01, 8'h00); run_cmd();
    set_cmd(8'h04, 8'h01, 8'h00); run_cmd();   // track 0 now set
    set_cmd(8'h08, 8'h00, 8'h00); run_cmd();

    // R3 flags ignored, R8 status variants, R9 read ID
    wp = 0; set_cmd(8'hE6, 8'h05, 8'h11); run_cmd();
    rdy = 0; set_cmd(8'h46, 8'h02, 8'h22); run_cmd();
    rdy = 1; wp = 1; set_cmd(8'h45, 8'h03, 8'h33); run_cmd();
    wp = 0; set_cmd(8'h4A, 8'h04, 8'h00); run_cmd();

    // R12 coincident strobes while collecting, stray read while collecting
    wr_data(8'h0F);
    both(8'h01, v);
    rd_reg(0, v); chk("R12 both strobes take write", v, 8'h90);
    rd_reg(1, v); chk("R12 read while collecting", v, 8'h00);
    rd_reg(0, v); chk("R13 status unchanged", v, 8'h90);
    wr_data(8'h10);
    wait_exec("R12", 4'b0010);
    chk("R12 seek done", v, 8'h80);
    m_cyl = 8'h10; m_irq = 1; m_ist0 = 8'h21;
    // R12 coincident strobes while results pend
    wr_data(8'h08);
    wait_exec("R6", 4'b0000);
    both(8'hFF, v); chk("R12 both strobes pop ST0", v, 8'h21);
    wr_data(8'h55);
    rd_reg(0, v); chk("R12 write ignored in result", v, 8'hD0);
    rd_reg(1, v); chk("R12 next result is cylinder", v, 8'h10);
    rd_reg(0, v); chk("R11 idle", v, 8'h80);
    m_irq = 0;
    chk("R6 irq cleared", {7'b0, irq}, 8'h00);

    // random command streams
    for (int it = 0; it < 160; it++) begin
      logic [7:0] op = ops[$urandom_range(0, 20)];
      cb[0] = op | (8'($urandom_range(0, 7)) << 5);
      for (int i = 1; i < 10; i++) cb[i] = 8'($urandom_range(0, 255));
      cn = w_len(cb[0][4:0]);
      {rdy, wp, ft, ts} = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) rdy = 1;
      run_cmd();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule